// File: doc/BRIEF.md
# Mailbox Command Issue Sequencer

This engine runs one command at a time through a device mailbox that sits behind a simple register bus. It is started by a strobe on its command port. It reads the mailbox control register and refuses the request at once if the doorbell is already set. Otherwise it writes the opcode and input length into the command register, copies the caller's input words into the payload window and rings the doorbell. It then polls the control register until the device clears the doorbell.

Once the device finishes, the engine reads the return code. On success it reads the reported output length and copies the output words back to the caller. The copy is clamped to the smallest of the caller's limit, the negotiated payload size and the reported length. A one-cycle completion pulse carries the return code, the number of bytes copied and an error code.

The poll limit is counted in milliseconds from a cycle prescaler. When the limit runs out, the engine samples the doorbell once more before it declares a timeout.

Top module: `mbox_issue_seq`

## Requirements
- R1: The first bus access of every command is a read of the control register (address 0x004). If its bit 0 (doorbell) is set, the command completes with error code 1 (busy), length 0, and no register is written.
- R2: If the doorbell is clear, the input length is nonzero and `cmd_in_given` is low, the command completes with error code 3 (invalid), length 0, and no register is written.
- R3: The command register (address 0x008) is written with the opcode in bits 15:0 and the input length in bits 36:16. It is followed by ceil(len/8) payload words at 0x100 + 8*i, each taken from `in_word` while `in_idx` = i. No payload word is written when the input length is zero.
- R4: The doorbell is rung by writing 1 to the control register, and only after the command register and all payload words have been written.
- R5: After the ring, the control register is read repeatedly until bit 0 reads 0. A poll acknowledged once CYC_PER_MS*TMO_MS cycles have elapsed since the ring is followed by exactly one further control read. The command ends with error code 2 (timeout), and without a status read, only if that read still shows the doorbell set.
- R6: The status register (address 0x010) is read after the doorbell clears. The return code is its bits 47:32. A nonzero code completes the command with error code 0, that return code and length 0, without reading the command register.
- R7: On a zero return code, the output length is taken from bits 36:16 of the command register (21 bits; higher bits are ignored). The byte count is the minimum of `cmd_out_max`, `pay_size` and that length.
- R8: A byte count of zero, or `cmd_out_given` low, completes with length 0 and no payload read.
- R9: For a nonzero byte count n, ceil(n/8) payload words are read from 0x100 + 8*i. Each word is presented on `out_word` with `out_idx` = i and `out_we` high for one cycle. Completion then reports error 0, return code 0 and length n.
- R10: A bus request keeps its address, direction and write data until it is acknowledged. `done` is high for exactly one cycle per command.
- R11: A start strobe that arrives while a command is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | Start strobe, taken only when idle |
| cmd_opcode | input | 16 | Command opcode |
| cmd_in_len | input | 21 | Input payload length in bytes |
| cmd_in_given | input | 1 | An input payload is supplied |
| cmd_out_max | input | 21 | Caller output buffer size in bytes |
| cmd_out_given | input | 1 | An output buffer is supplied |
| pay_size | input | 21 | Negotiated payload window size in bytes |
| in_idx | output | 18 | Index of the input word being fetched |
| in_word | input | 64 | Input word at `in_idx` |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 24 | Byte address of the register |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | Access complete, read data valid |
| bus_rdata | input | 64 | Read data |
| out_we | output | 1 | Output word strobe |
| out_idx | output | 18 | Output word index |
| out_word | output | 64 | Output word |
| done | output | 1 | Completion pulse |
| done_rc | output | 16 | Device return code |
| done_len | output | 21 | Bytes copied to the caller |
| done_err | output | 2 | 0 none, 1 busy, 2 timeout, 3 invalid |

## Verification
The hardest situation to bring about is the last-chance recheck. The device must keep the doorbell set on the very poll that sees the limit expire, then clear it just before the single extra read. The bench's mailbox model counts clock edges from the acknowledged ring write. It answers busy until a poll is acknowledged at or after the limit, then shows the doorbell clear on the next read. A second mode holds the doorbell set forever to reach the true timeout. Clamping is exercised with each of the three lengths in turn as the smallest, including a reported length with garbage above the 21-bit field.

// File: rtl/mbox_issue_seq.sv
module mbox_issue_seq #(
  parameter int AW = 24,
  parameter int LW = 21,
  parameter int CYC_PER_MS = 100000,
  parameter int TMO_MS = 2000,
  parameter logic [AW-1:0] A_CTRL = 'h004,
  parameter logic [AW-1:0] A_CMD  = 'h008,
  parameter logic [AW-1:0] A_STAT = 'h010,
  parameter logic [AW-1:0] A_PAY  = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [15:0]   cmd_opcode,
  input  logic [LW-1:0] cmd_in_len,
  input  logic          cmd_in_given,
  input  logic [LW-1:0] cmd_out_max,
  input  logic          cmd_out_given,
  input  logic [LW-1:0] pay_size,
  output logic [LW-4:0] in_idx,
  input  logic [63:0]   in_word,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [63:0]   bus_wdata,
  input  logic          bus_ack,
  input  logic [63:0]   bus_rdata,
  output logic          out_we,
  output logic [LW-4:0] out_idx,
  output logic [63:0]   out_word,
  output logic          done,
  output logic [15:0]   done_rc,
  output logic [LW-1:0] done_len,
  output logic [1:0]    done_err
);
  localparam int WW = LW - 2;
  localparam int IW = LW - 3;
  localparam int PW = $clog2(CYC_PER_MS + 1);
  localparam int MW = $clog2(TMO_MS + 1);
  localparam logic [1:0] E_NONE = 2'd0, E_BUSY = 2'd1, E_TMO = 2'd2, E_INV = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_WCMD, S_WPAY, S_RING, S_POLL, S_RECHK, S_RSTAT, S_RCMD, S_RPAY
  } st_t;

  st_t           st;
  logic [15:0]   opc;
  logic [LW-1:0] ilen, omax, psz, clen;
  logic          igiv, ogiv;
  logic [WW-1:0] widx;
  logic [PW-1:0] presc;
  logic [MW-1:0] ms;

  wire [WW-1:0] in_words = WW'(({1'b0, ilen} + (LW+1)'(7)) >> 3);
  wire [WW-1:0] cp_words = WW'(({1'b0, clen} + (LW+1)'(7)) >> 3);
  wire          expired  = (ms == MW'(TMO_MS));
  wire [LW-1:0] rep      = bus_rdata[16 +: LW];
  wire [LW-1:0] lim      = (omax < psz) ? omax : psz;
  wire [LW-1:0] ncopy    = !ogiv ? '0 : ((rep < lim) ? rep : lim);
  wire [15:0]   rc_w     = bus_rdata[47:32];
  wire          db       = bus_rdata[0];

  assign in_idx  = widx[IW-1:0];
  assign bus_req = (st != S_IDLE);
  assign bus_we  = (st == S_WCMD) || (st == S_WPAY) || (st == S_RING);

  always_comb begin
    case (st)
      S_CHK, S_RING, S_POLL, S_RECHK: bus_addr = A_CTRL;
      S_WCMD, S_RCMD:                 bus_addr = A_CMD;
      S_RSTAT:                        bus_addr = A_STAT;
      S_WPAY, S_RPAY:                 bus_addr = A_PAY + AW'({widx[IW-1:0], 3'b000});
      default:                        bus_addr = '0;
    endcase
    case (st)
      S_WCMD:  bus_wdata = {(64-16-LW)'(0), ilen, opc};
      S_WPAY:  bus_wdata = in_word;
      S_RING:  bus_wdata = 64'd1;
      default: bus_wdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; opc <= '0; ilen <= '0; omax <= '0; psz <= '0; clen <= '0;
      igiv <= 1'b0; ogiv <= 1'b0; widx <= '0; presc <= '0; ms <= '0;
      out_we <= 1'b0; out_idx <= '0; out_word <= '0;
      done <= 1'b0; done_rc <= '0; done_len <= '0; done_err <= E_NONE;
    end else begin
      done   <= 1'b0;
      out_we <= 1'b0;
      case (st)
        S_IDLE: if (cmd_start) begin
          opc <= cmd_opcode; ilen <= cmd_in_len; igiv <= cmd_in_given;
          omax <= cmd_out_max; ogiv <= cmd_out_given; psz <= pay_size;
          st <= S_CHK;
        end
        S_CHK: if (bus_ack) begin
          if (db || (ilen != '0 && !igiv)) begin
            done <= 1'b1; done_rc <= '0; done_len <= '0;
            done_err <= db ? E_BUSY : E_INV; st <= S_IDLE;
          end else st <= S_WCMD;
        end
        S_WCMD: if (bus_ack) begin
          widx <= '0;
          st <= (ilen != '0) ? S_WPAY : S_RING;
        end
        S_WPAY: if (bus_ack) begin
          widx <= widx + 1'b1;
          if (widx == in_words - 1'b1) st <= S_RING;
        end
        S_RING: if (bus_ack) begin
          presc <= '0; ms <= '0; st <= S_POLL;
        end
        S_POLL: begin
          if (presc == PW'(CYC_PER_MS - 1)) begin
            presc <= '0;
            if (!expired) ms <= ms + 1'b1;
          end else presc <= presc + 1'b1;
          if (bus_ack) begin
            if (!db) st <= S_RSTAT;
            else if (expired) st <= S_RECHK;
          end
        end
        S_RECHK: if (bus_ack) begin
          if (db) begin
            done <= 1'b1; done_rc <= '0; done_len <= '0; done_err <= E_TMO; st <= S_IDLE;
          end else st <= S_RSTAT;
        end
        S_RSTAT: if (bus_ack) begin
          if (rc_w != '0) begin
            done <= 1'b1; done_rc <= rc_w; done_len <= '0; done_err <= E_NONE; st <= S_IDLE;
          end else st <= S_RCMD;
        end
        S_RCMD: if (bus_ack) begin
          if (ncopy == '0) begin
            done <= 1'b1; done_rc <= '0; done_len <= '0; done_err <= E_NONE; st <= S_IDLE;
          end else begin
            clen <= ncopy; widx <= '0; st <= S_RPAY;
          end
        end
        S_RPAY: if (bus_ack) begin
          out_we <= 1'b1; out_idx <= widx[IW-1:0]; out_word <= bus_rdata;
          widx <= widx + 1'b1;
          if (widx == cp_words - 1'b1) begin
            done <= 1'b1; done_rc <= '0; done_len <= clen; done_err <= E_NONE; st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_CHK && bus_ack && bus_rdata[0] |=> done && done_err == E_BUSY && !bus_req);
  assert_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err == E_INV |-> done_len == '0 && done_rc == '0);
  assert_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_addr == A_CTRL |-> $past(bus_req) && $past(bus_we));
  assert_tmo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err == E_TMO |-> $past(st) == S_RECHK);
  assert_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err == E_NONE |-> done_len <= omax && done_len <= psz);
endmodule

// File: tb/sim_mbox_issue_seq.sv
module sim_mbox_issue_seq;
  localparam int CPM = 4, TMO = 3, LIMIT = CPM * TMO;
  localparam logic [23:0] A_CTRL = 'h004, A_CMD = 'h008, A_STAT = 'h010, A_PAY = 'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_in_given = 1'b0, cmd_out_given = 1'b0;
  logic [15:0] cmd_opcode = '0;
  logic [20:0] cmd_in_len = '0, cmd_out_max = '0, pay_size = '0;
  logic [17:0] in_idx, out_idx;
  logic [63:0] in_word, bus_wdata, out_word;
  logic bus_req, bus_we, out_we, done;
  logic [23:0] bus_addr;
  logic bus_ack = 1'b0;
  logic [63:0] bus_rdata = '0;
  logic [15:0] done_rc;
  logic [20:0] done_len;
  logic [1:0] done_err;

  logic [63:0] inpay [0:15];
  logic [63:0] dpay [0:15];
  assign in_word = inpay[in_idx[3:0]];

  mbox_issue_seq #(.CYC_PER_MS(CPM), .TMO_MS(TMO)) u0 (
    .clk, .rst_n, .cmd_start, .cmd_opcode, .cmd_in_len, .cmd_in_given,
    .cmd_out_max, .cmd_out_given, .pay_size, .in_idx, .in_word,
    .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_ack, .bus_rdata,
    .out_we, .out_idx, .out_word, .done, .done_rc, .done_len, .done_err);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  bit q_we[$]; logic [23:0] q_addr[$]; logic [63:0] q_data[$]; bit q_poll[$];
  int qo_idx[$]; logic [63:0] qo_data[$];
  bit db = 0, rang = 0, stick = 0, remode = 0, late = 0;
  int busy_reads = 0, reads_seen = 0, ring_edge = 0, lat = 0, wcnt = 0;
  logic [15:0] d_rc = '0;
  logic [63:0] d_cmdret = '0;
  bit exp_on = 0, done_seen = 0;
  logic [1:0] e_err; logic [15:0] e_rc; logic [20:0] e_len;

  task automatic push(bit we, logic [23:0] a, logic [63:0] d, bit p);
    q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d); q_poll.push_back(p);
  endtask

  task automatic serve();
    logic [63:0] rd = '0;
    bit expiry;
    int idx;
    expiry = rang && (cyc - ring_edge >= LIMIT);
    if (bus_we) begin
      if (bus_addr == A_CTRL && bus_wdata[0]) begin
        db = 1; rang = 1; ring_edge = cyc + 1; reads_seen = 0; late = 0;
        expiry = 0;
      end
    end else if (bus_addr == A_CTRL) begin
      if (!rang) rd = {63'd0, db};
      else if (stick) rd = 64'd1;
      else if (remode) begin
        if (late) begin db = 0; rd = 0; end
        else begin rd = 64'd1; if (expiry) late = 1; end
      end else if (reads_seen < busy_reads) begin reads_seen++; rd = 64'd1; end
      else begin db = 0; rd = 0; end
    end else if (bus_addr == A_STAT) rd = {16'h0, d_rc, 32'h0};
    else if (bus_addr == A_CMD) rd = d_cmdret;
    else begin idx = int'(bus_addr - A_PAY) >> 3; rd = dpay[idx[3:0]]; end
    bus_rdata = rd;
    if (q_we.size() == 0) chk("R4 unexpected bus access", {40'd0, bus_addr}, 64'hFFFFFF);
    else begin
      chk("R4 bus direction", {63'd0, bus_we}, {63'd0, q_we[0]});
      chk("R3 bus address", {40'd0, bus_addr}, {40'd0, q_addr[0]});
      if (bus_we) chk("R3 write data", bus_wdata, q_data[0]);
      if (!q_poll[0] || rd[0] == 0 || expiry) begin
        void'(q_we.pop_front()); void'(q_addr.pop_front());
        void'(q_data.pop_front()); void'(q_poll.pop_front());
      end
    end
  endtask

  always @(negedge clk) begin
    if (out_we) begin
      if (qo_idx.size() == 0) chk("R9 unexpected output word", {46'd0, out_idx}, 64'hFFFFF);
      else begin
        chk("R9 output index", {46'd0, out_idx}, 64'(qo_idx.pop_front()));
        chk("R9 output word", out_word, qo_data.pop_front());
      end
    end
    if (done) begin
      if (!exp_on) chk("R10 unexpected done", 1, 0);
      else begin
        chk("R6 done return code", {48'd0, done_rc}, {48'd0, e_rc});
        chk("R7 done length", {43'd0, done_len}, {43'd0, e_len});
        chk("R5 done error", {62'd0, done_err}, {62'd0, e_err});
      end
      exp_on = 0; done_seen = 1;
    end
    if (bus_ack) bus_ack = 0;
    else if (bus_req && rst_n) begin
      if (wcnt < lat) wcnt++;
      else begin wcnt = 0; serve(); bus_ack = 1; end
    end
  end

  task automatic run_cmd(string tag, logic [15:0] opc, logic [20:0] ilen, bit igiv,
                         logic [20:0] omax, bit ogiv, logic [20:0] psz, bit restart);
    int nw, n;
    logic [20:0] r;
    push(0, A_CTRL, 0, 0);
    e_rc = 0; e_len = 0; e_err = 0;
    if (db) e_err = 1;
    else if (ilen != 0 && !igiv) e_err = 3;
    else begin
      push(1, A_CMD, {27'd0, ilen, opc}, 0);
      nw = (int'(ilen) + 7) / 8;
      for (int i = 0; i < nw; i++) push(1, A_PAY + 24'(8 * i), inpay[i], 0);
      push(1, A_CTRL, 64'd1, 0);
      push(0, A_CTRL, 0, 1);
      if (stick) begin push(0, A_CTRL, 0, 0); e_err = 2; end
      else begin
        if (remode) push(0, A_CTRL, 0, 0);
        push(0, A_STAT, 0, 0);
        if (d_rc != 0) e_rc = d_rc;
        else begin
          push(0, A_CMD, 0, 0);
          r = d_cmdret[36:16];
          n = int'(omax);
          if (int'(psz) < n) n = int'(psz);
          if (int'(r) < n) n = int'(r);
          if (!ogiv) n = 0;
          for (int i = 0; i < (n + 7) / 8; i++) begin
            push(0, A_PAY + 24'(8 * i), 0, 0);
            qo_idx.push_back(i); qo_data.push_back(dpay[i]);
          end
          e_len = 21'(n);
        end
      end
    end
    exp_on = 1; done_seen = 0;
    @(negedge clk);
    cmd_opcode = opc; cmd_in_len = ilen; cmd_in_given = igiv;
    cmd_out_max = omax; cmd_out_given = ogiv; pay_size = psz; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    for (int k = 0; k < 2000 && !done_seen; k++) begin
      @(negedge clk);
      if (restart && k == 3) begin cmd_opcode = 16'hDEAD; cmd_start = 1; end
      else cmd_start = 0;
    end
    cmd_start = 0;
    chk({tag, " completion seen"}, {63'd0, done_seen}, 64'd1);
    chk({tag, " R11 all bus accesses made"}, 64'(q_we.size()), 0);
    chk({tag, " R9 all output words"}, 64'(qo_idx.size()), 0);
    q_we.delete(); q_addr.delete(); q_data.delete(); q_poll.delete();
    qo_idx.delete(); qo_data.delete();
    db = 0; rang = 0; stick = 0; remode = 0; late = 0; busy_reads = 0; d_rc = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      inpay[i] = {32'hC0DE0000 + 32'(i), 32'h5A5A0000 + 32'(3 * i)};
      dpay[i]  = {32'hBEEF0000 + 32'(i), 32'h0F0F0000 + 32'(7 * i)};
    end
    repeat (3) @(negedge clk);
    chk("R10 reset bus_req", {63'd0, bus_req}, 0);
    chk("R10 reset done", {63'd0, done}, 0);
    chk("R9 reset out_we", {63'd0, out_we}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R3 R4 R9 R11: basic command, mid-run start ignored
    lat = 1; busy_reads = 2; d_cmdret = {27'd0, 21'd30, 16'h0};
    run_cmd("R3 basic", 16'h1234, 21'd20, 1, 21'd64, 1, 21'd256, 1);
    // R3 R8: no input payload, zero reported length
    lat = 0; busy_reads = 0; d_cmdret = {27'd0, 21'd0, 16'h0};
    run_cmd("R8 zero lengths", 16'h0042, 21'd0, 0, 21'd64, 1, 21'd256, 0);
    // R1: doorbell already set
    db = 1;
    run_cmd("R1 busy", 16'h0101, 21'd8, 1, 21'd64, 1, 21'd256, 0);
    // R2: missing input payload
    lat = 2;
    run_cmd("R2 invalid", 16'h0202, 21'd8, 0, 21'd64, 1, 21'd256, 0);
    // R5: true timeout
    lat = 0; stick = 1;
    run_cmd("R5 timeout", 16'h0303, 21'd0, 0, 21'd64, 1, 21'd256, 0);
    // R5: recheck finds the doorbell clear
    remode = 1; d_cmdret = {27'd0, 21'd12, 16'h0};
    run_cmd("R5 recheck", 16'h0404, 21'd9, 1, 21'd64, 1, 21'd256, 0);
    // R6: nonzero return code
    lat = 1; busy_reads = 1; d_rc = 16'h0005;
    run_cmd("R6 rc error", 16'h0505, 21'd0, 0, 21'd64, 1, 21'd256, 0);
    // R7: clamp by caller limit
    d_cmdret = {27'd0, 21'd100, 16'h0};
    run_cmd("R7 clamp limit", 16'h0606, 21'd0, 0, 21'd17, 1, 21'd256, 0);
    // R7: clamp by payload size
    run_cmd("R7 clamp paysize", 16'h0707, 21'd0, 0, 21'd64, 1, 21'd16, 0);
    // R7: 21-bit field with garbage above
    d_cmdret = {27'h2AAAAAA, 21'h1FFFFF, 16'hFFFF};
    run_cmd("R7 wide field", 16'h0808, 21'd0, 0, 21'd24, 1, 21'd1024, 0);
    // R8: no output buffer
    d_cmdret = {27'd0, 21'd40, 16'h0};
    run_cmd("R8 no buffer", 16'h0909, 21'd1, 1, 21'd64, 0, 21'd256, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog expired R10 actual=hung expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule